// File: doc/BRIEF.md
# Time-Base Prescaler and Control Register

This block sits at the front of a serial bus interface. It holds one small control register and turns a fast input clock into a one-cycle tick enable, which the symbol timing logic downstream uses as its base time step. The divide ratio is a power of two (1, 2, 4 or 8), chosen by a two-bit rate field. Software may set that field only once after each reset; after that, the field does not change until the next reset.

The same register holds three more bits. A base-select bit tells the symbol timing logic whether the tick stream runs at the binary rate (1.048576 MHz) or the integer rate (1 MHz). An interrupt-enable bit gates the interrupt request output. A wait-stop bit lets software freeze the time base while the CPU is in wait mode. The per-source interrupt events are latched here and held until each one is cleared by its own strobe.

Top module: `tbase_ctl_top`

## Requirements
- R1: After reset, `rd_data` reads all zeros, `irq` is low, and the rate field is unlocked.
- R2: `rd_data[1:0]` holds the rate code. Code 01 divides by 2, 10 divides by 4 and 11 divides by 8. With code c, `tick` is high for one cycle in every 2^c cycles in which the time base runs. The first tick comes 2^c cycles after the rate write.
- R3: The first register write after reset loads the rate field and locks it. Any later write leaves `rd_data[1:0]` unchanged until reset.
- R4: `rd_data[2]` is the base-select bit (1 = binary rate, 0 = integer rate) and is driven on `base_binary`. It and bits 3 and 4 take the written value on every write, whether or not the rate field is locked. Bits above 4 read as 0.
- R5: `irq` equals `rd_data[3]` AND (any source pending). It is low whenever bit 3 is 0.
- R6: A pulse on `src_set[i]` marks source i pending. A pulse on `src_clr[i]` clears it. If both arrive in the same cycle, the set wins. Pending state is held until it is cleared, so `irq` stays high until every pending source has been cleared.
- R7: A write that changes bit 3 from 1 to 0 discards all pending flags, including any set in that same cycle. Setting bit 3 again later does not bring them back.
- R8: While `rd_data[4]` is 1 and `cpu_wait` is high, `tick` is low and the divider count is held. Counting resumes from where it stopped.
- R9: While `rd_data[4]` is 0, `cpu_wait` has no effect on `tick`.
- R10: With rate code 00, `tick` is high on every cycle in which the time base runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| cpu_wait | input | 1 | High while the CPU is in wait mode |
| src_set | input | 4 | Per-source interrupt event pulses |
| src_clr | input | 4 | Per-source clear strobes |
| tick | output | 1 | One-cycle time-base enable |
| base_binary | output | 1 | Base-select bit for symbol timing |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every input changes only between clock edges and that `src_set` and `src_clr` are single-cycle pulses. They also assume that the rate field starts at code 00 after reset, so the divide-by-1 property never sees a stale count. The bench drives all inputs on the falling edge. It applies a new rate only right after a fresh reset, and it holds the CPU wait input only long enough to observe a frozen count before releasing it.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
   // Field placement inside the control word, derived from the rate width.
   function automatic int cs_pos(input int rate_w);
      return rate_w;
   endfunction
   function automatic int ie_pos(input int rate_w);
      return rate_w + 1;
   endfunction
   function automatic int ws_pos(input int rate_w);
      return rate_w + 2;
   endfunction

   typedef struct packed {
      logic ws;
      logic ie;
      logic cs;
   } ctl_flags_t;
endpackage

// File: rtl/tbase_regs.sv
module tbase_regs #(
   parameter int DATA_W = 8,
   parameter int RATE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [RATE_W-1:0] rate,
   output tbase_pkg::ctl_flags_t flags,
   output logic              locked,
   output logic              ie_fall
);
   import tbase_pkg::*;
   localparam int CS_P = cs_pos(RATE_W);
   localparam int IE_P = ie_pos(RATE_W);
   localparam int WS_P = ws_pos(RATE_W);

   initial begin
      if (DATA_W < RATE_W + 3) $error("tbase_regs: DATA_W too small for control word");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate   <= '0;
         locked <= 1'b0;
         flags  <= '0;
      end else if (wr_en) begin
         if (!locked) begin
            rate   <= wr_data[RATE_W-1:0];
            locked <= 1'b1;
         end
         flags.cs <= wr_data[CS_P];
         flags.ie <= wr_data[IE_P];
         flags.ws <= wr_data[WS_P];
      end
   end

   always_comb ie_fall = wr_en & flags.ie & ~wr_data[IE_P];
endmodule

// File: rtl/tbase_div.sv
module tbase_div #(
   parameter int RATE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate,
   input  logic              run,
   output logic              tick
);
   localparam int CNT_W = (1 << RATE_W) - 1;

   initial begin
      if (RATE_W < 1 || RATE_W > 4) $error("tbase_div: RATE_W out of range");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;
   logic             at_last;

   always_comb begin
      last    = CNT_W'((32'd1 << rate) - 32'd1);
      at_last = (cnt >= last);
      tick    = run & at_last;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (run)  cnt <= at_last ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/tbase_irq.sv
module tbase_irq #(
   parameter int NSRC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_set,
   input  logic [NSRC-1:0] src_clr,
   input  logic            ie,
   input  logic            drop_all,
   output logic            irq
);
   initial begin
      if (NSRC < 1) $error("tbase_irq: NSRC must be at least 1");
   end

   logic [NSRC-1:0] pend;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           pend[i] <= 1'b0;
         else if (drop_all)    pend[i] <= 1'b0;
         else if (src_set[i])  pend[i] <= 1'b1;
         else if (src_clr[i])  pend[i] <= 1'b0;
      end
   end

   always_comb irq = ie & (|pend);
endmodule

// File: rtl/tbase_ctl_top.sv
module tbase_ctl_top #(
   parameter int DATA_W = 8,
   parameter int RATE_W = 2,
   parameter int NSRC   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              cpu_wait,
   input  logic [NSRC-1:0]   src_set,
   input  logic [NSRC-1:0]   src_clr,
   output logic              tick,
   output logic              base_binary,
   output logic              irq
);
   import tbase_pkg::*;

   logic [RATE_W-1:0] rate;
   ctl_flags_t        flags;
   logic              rate_locked;
   logic              ie_fall;
   logic              run;

   tbase_regs #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rate(rate), .flags(flags), .locked(rate_locked), .ie_fall(ie_fall)
   );

   always_comb run = ~(flags.ws & cpu_wait);

   tbase_div #(.RATE_W(RATE_W)) u_div (
      .clk(clk), .rst_n(rst_n), .rate(rate), .run(run), .tick(tick)
   );

   tbase_irq #(.NSRC(NSRC)) u_irq (
      .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
      .ie(flags.ie), .drop_all(ie_fall), .irq(irq)
   );

   always_comb begin
      rd_data = '0;
      rd_data[RATE_W-1:0]            = rate;
      rd_data[RATE_W+2:RATE_W]       = {flags.ws, flags.ie, flags.cs};
      base_binary                    = flags.cs;
   end
endmodule

// File: rtl/tbase_ctl_chk.sv
module tbase_ctl_chk #(
   parameter int DATA_W = 8,
   parameter int RATE_W = 2,
   parameter int NSRC   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] rd_data,
   input logic              cpu_wait,
   input logic [NSRC-1:0]   src_clr,
   input logic              tick,
   input logic              base_binary,
   input logic              irq,
   input logic              rate_locked
);
   localparam int IE_P = RATE_W + 1;
   localparam int WS_P = RATE_W + 2;

   assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[IE_P] |-> !irq);

   assert_wait_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[WS_P] && cpu_wait) |-> !tick);

   assert_rate_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rate_locked) |=> $stable(rd_data[RATE_W-1:0]));

   assert_irq_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !wr_en && (src_clr == '0)) |=> irq);

   assert_div1_every_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_data[RATE_W-1:0] == '0) && !(rd_data[WS_P] && cpu_wait)) |-> tick);

   assert_base_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
      base_binary == rd_data[RATE_W]);
endmodule

bind tbase_ctl_top tbase_ctl_chk #(.DATA_W(DATA_W), .RATE_W(RATE_W), .NSRC(NSRC)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data(rd_data), .cpu_wait(cpu_wait),
   .src_clr(src_clr), .tick(tick), .base_binary(base_binary), .irq(irq),
   .rate_locked(rate_locked)
);

// File: tb/tb_tbase_ctl_top.sv
module tb_tbase_ctl_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       cpu_wait = 1'b0;
   logic [3:0] src_set = '0;
   logic [3:0] src_clr = '0;
   logic       tick, base_binary, irq;

   int checks = 0;
   int failures = 0;
   string phase = "R1";
   bit done = 1'b0;

   always #10 clk = ~clk;

   tbase_ctl_top dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .cpu_wait(cpu_wait), .src_set(src_set), .src_clr(src_clr),
      .tick(tick), .base_binary(base_binary), .irq(irq)
   );

   typedef struct {
      logic       tick;
      logic       irq;
      logic       base;
      logic [7:0] rd;
      string      tag;
   } exp_t;
   exp_t sb[$];

   // Requirement model
   logic [1:0] m_rate = '0;
   logic       m_lock = 1'b0, m_cs = 1'b0, m_ie = 1'b0, m_ws = 1'b0;
   int         m_cnt = 0;
   logic [3:0] m_pend = '0;

   always @(posedge clk) begin
      exp_t e;
      if (!rst_n) begin
         m_rate = '0; m_lock = 0; m_cs = 0; m_ie = 0; m_ws = 0; m_cnt = 0; m_pend = '0;
      end else begin
         if (!(m_ws && cpu_wait))
            m_cnt = (m_cnt >= (1 << m_rate) - 1) ? 0 : m_cnt + 1;
         if (wr_en && m_ie && !wr_data[3]) m_pend = '0;
         else m_pend = (m_pend & ~src_clr) | src_set;
         if (wr_en) begin
            if (!m_lock) begin m_rate = wr_data[1:0]; m_lock = 1; end
            m_cs = wr_data[2]; m_ie = wr_data[3]; m_ws = wr_data[4];
         end
      end
      #4;
      e.tick = !(m_ws && cpu_wait) && (m_cnt >= (1 << m_rate) - 1);
      e.irq  = m_ie && (m_pend != 0);
      e.base = m_cs;
      e.rd   = {3'b000, m_ws, m_ie, m_cs, m_rate};
      e.tag  = phase;
      sb.push_back(e);
   end

   task automatic cmp(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #5;
      while (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         cmp(e.tag, "tick", {7'd0, tick}, {7'd0, e.tick});
         cmp(e.tag, "irq", {7'd0, irq}, {7'd0, e.irq});
         cmp(e.tag, "base_binary", {7'd0, base_binary}, {7'd0, e.base});
         cmp(e.tag, "rd_data", rd_data, e.rd);
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wreg(input logic [7:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_set(input logic [3:0] v);
      @(negedge clk); src_set = v;
      @(negedge clk); src_set = '0;
   endtask

   task automatic pulse_clr(input logic [3:0] v);
      @(negedge clk); src_clr = v;
      @(negedge clk); src_clr = '0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
   endtask

   initial begin
      // R1: reset state
      phase = "R1";
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R10 and R9: divide-by-1 with wait-stop off, CPU waiting
      phase = "R10";
      idle(4);
      phase = "R9";
      cpu_wait = 1'b1; idle(4); cpu_wait = 1'b0;
      // R2: each ratio after a fresh reset
      for (int r = 1; r < 4; r++) begin
         do_reset();
         phase = "R2";
         wreg(8'(r));
         idle(20);
      end
      // R3: later write does not change the rate
      phase = "R3";
      wreg(8'h01);
      idle(12);
      // R4: base-select and upper bits while locked
      phase = "R4";
      wreg(8'hE7);
      idle(3);
      wreg(8'h03);
      idle(2);
      // R8: wait freeze mid-count
      phase = "R8";
      wreg(8'h10);
      idle(3);
      cpu_wait = 1'b1; idle(7); cpu_wait = 1'b0;
      idle(12);
      // R9: wait-stop off again
      phase = "R9";
      wreg(8'h00);
      cpu_wait = 1'b1; idle(10); cpu_wait = 1'b0;
      // R5: pending while disabled, then enable
      phase = "R5";
      pulse_set(4'b0101);
      idle(2);
      wreg(8'h08);
      idle(2);
      // R6: clear one at a time, set beats clear
      phase = "R6";
      pulse_clr(4'b0001);
      idle(2);
      @(negedge clk); src_set = 4'b0100; src_clr = 4'b0100;
      @(negedge clk); src_set = '0; src_clr = '0;
      idle(2);
      pulse_clr(4'b0100);
      idle(2);
      // R7: dropping enable discards pending, including a same-cycle set
      phase = "R7";
      pulse_set(4'b1010);
      idle(1);
      @(negedge clk); wr_en = 1'b1; wr_data = 8'h00; src_set = 4'b0001;
      @(negedge clk); wr_en = 1'b0; src_set = '0;
      idle(2);
      wreg(8'h08);
      idle(3);
      // R1 again: reset mid-activity
      phase = "R1";
      pulse_set(4'b1111);
      do_reset();
      idle(3);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule